// File: doc/BRIEF.md
# Memory ECC Single-Bit Error Tally

This block sits beside the ECC checker on a memory controller's read-data path. For every read the checker reports a two-bit classification. The block turns single-bit reports into a running count and turns multibit reports into an immediate sticky flag. Single-bit errors therefore raise no flag one by one. Instead, a software-programmable trigger value sets how many of them must pile up before the threshold flag is raised.

Software can load the count and the trigger value, and can read both of them back. It clears either sticky flag with a one-cycle clear pulse. All activity from the read path is qualified by an ECC enable input. While that input is low, reads change neither the count nor the flags.

The count is a parameterised register (8 bits by default). By default it saturates at its maximum value, and a build option makes it wrap instead. The threshold flag is set only on the increment that makes the count equal to the trigger value. A trigger of zero never matches.

Top module: `ecc_err_tally`

## Requirements
- R1: When reset is released, the count is 0, the trigger is 0, and both flags are 0.
- R2: When ecc_on=1, rd_valid=1 and rd_class=2'b01 (single-bit), the count rises by exactly 1 at the next clock edge. rd_class=2'b00 (no error) and the multibit codes leave the count unchanged.
- R3: While ecc_on=0, a read of any class changes neither the count nor either flag.
- R4: A single-bit read at the maximum count (255 with the default width) leaves the count at the maximum.
- R5: The threshold flag sbe_flag is set at the same edge at which an increment makes the count equal to the trigger. The comparison uses the trigger value held before that edge.
- R6: While the trigger is 0, the threshold flag is never set.
- R7: An increment that does not produce equality does not set the threshold flag. This covers increments past the trigger and a single-bit read at saturation.
- R8: A read with ecc_on=1, rd_valid=1 and rd_class=2'b10 or 2'b11 (multibit) sets mbe_flag at the next edge.
- R9: sw_wr_count loads sw_wdata into the count. In the same cycle it overrides an increment, and that suppressed increment cannot set the threshold flag.
- R10: clr_sbe and clr_mbe clear their flag at the next edge. If a set condition occurs in the same cycle as the clear, the set wins.
- R11: sw_wr_trigger loads sw_wdata into the trigger, and trigger_out shows the new value after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_on | input | 1 | ECC checking and counting enable |
| rd_valid | input | 1 | A classified memory read is present this cycle |
| rd_class | input | 2 | 00 no error, 01 single-bit, 10/11 multibit |
| sw_wr_count | input | 1 | Software load of the count |
| sw_wr_trigger | input | 1 | Software load of the trigger |
| sw_wdata | input | CNT_W | Software write data |
| clr_sbe | input | 1 | Clear pulse for the threshold flag |
| clr_mbe | input | 1 | Clear pulse for the multibit flag |
| count_out | output | CNT_W | Current single-bit error count |
| trigger_out | output | CNT_W | Current trigger value |
| sbe_flag | output | 1 | Sticky single-bit threshold flag |
| mbe_flag | output | 1 | Sticky multibit error flag |

## Verification
The assertions assume that rd_class carries meaning only when rd_valid is high. They also assume that a software load and a read event in the same cycle are legal, and that software resolves them by priority rather than avoiding them. The stimulus drives every input at the falling edge and returns it to idle for the next step. Collisions are applied on purpose: a load against an increment, a clear against a set, and a read at saturation. The classification code is never left floating.

// File: rtl/ecc_tally_pkg.sv
package ecc_tally_pkg;

   typedef enum logic [1:0] {
      CLS_CLEAN  = 2'b00,
      CLS_SINGLE = 2'b01,
      CLS_MULTI  = 2'b10,
      CLS_MULTI2 = 2'b11
   } ecc_cls_e;

   function automatic logic is_multi(input logic [1:0] cls);
      return cls[1];
   endfunction

endpackage

// File: rtl/ecc_cls_decode.sv
module ecc_cls_decode
   import ecc_tally_pkg::*;
(
   input  logic       enable,
   input  logic       valid,
   input  logic [1:0] cls,
   output logic       single_evt,
   output logic       multi_evt
);

   logic qualified;

   always_comb begin
      qualified  = enable & valid;
      single_evt = qualified & (cls == CLS_SINGLE);
      multi_evt  = qualified & is_multi(cls);
   end

endmodule

// File: rtl/ecc_tally_counter.sv
module ecc_tally_counter #(
   parameter int unsigned W        = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic [W-1:0] bumped_val,
   output logic         bumped
);

   localparam logic [W-1:0] TOP = {W{1'b1}};
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic         can_step;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("ecc_tally_counter: W must lie in 2..32");
      end
      if (SATURATE) begin : g_sat
         assign can_step = (cnt_q != TOP);
      end else begin : g_wrap
         assign can_step = 1'b1;
      end
   endgenerate

   always_comb begin
      bumped_val = cnt_q + ONE;
      bumped     = inc & ~load & can_step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (bumped) begin
         cnt_q <= bumped_val;
      end
   end

   assign value = cnt_q;

endmodule

// File: rtl/ecc_trigger_match.sv
module ecc_trigger_match #(
   parameter int unsigned W             = 8,
   parameter bit          ZERO_DISABLES = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         bumped,
   input  logic [W-1:0] bumped_val,
   output logic [W-1:0] trigger,
   output logic         hit
);

   logic [W-1:0] trig_q;
   logic         armed;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("ecc_trigger_match: W must lie in 2..32");
      end
      if (ZERO_DISABLES) begin : g_zero_off
         assign armed = (trig_q != '0);
      end else begin : g_zero_on
         assign armed = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= '0;
      end else if (load) begin
         trig_q <= load_val;
      end
   end

   assign hit     = bumped & armed & (bumped_val == trig_q);
   assign trigger = trig_q;

endmodule

// File: rtl/ecc_sticky_flag.sv
module ecc_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   logic q_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= 1'b0;
      end else if (set) begin
         q_r <= 1'b1;
      end else if (clr) begin
         q_r <= 1'b0;
      end
   end

   assign q = q_r;

endmodule

// File: rtl/ecc_err_tally.sv
module ecc_err_tally #(
   parameter int unsigned CNT_W         = 8,
   parameter bit          SATURATE      = 1'b1,
   parameter bit          ZERO_DISABLES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ecc_on,
   input  logic             rd_valid,
   input  logic [1:0]       rd_class,
   input  logic             sw_wr_count,
   input  logic             sw_wr_trigger,
   input  logic [CNT_W-1:0] sw_wdata,
   input  logic             clr_sbe,
   input  logic             clr_mbe,
   output logic [CNT_W-1:0] count_out,
   output logic [CNT_W-1:0] trigger_out,
   output logic             sbe_flag,
   output logic             mbe_flag
);

   localparam int unsigned NFLAGS = 2;
   localparam int unsigned F_SBE  = 0;
   localparam int unsigned F_MBE  = 1;

   logic             single_evt;
   logic             multi_evt;
   logic             step_taken;
   logic [CNT_W-1:0] step_val;
   logic             trig_hit;
   logic [NFLAGS-1:0] flag_set;
   logic [NFLAGS-1:0] flag_clr;
   logic [NFLAGS-1:0] flag_q;

   ecc_cls_decode u_decode (
      .enable     (ecc_on),
      .valid      (rd_valid),
      .cls        (rd_class),
      .single_evt (single_evt),
      .multi_evt  (multi_evt)
   );

   ecc_tally_counter #(
      .W        (CNT_W),
      .SATURATE (SATURATE)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (sw_wr_count),
      .load_val   (sw_wdata),
      .inc        (single_evt),
      .value      (count_out),
      .bumped_val (step_val),
      .bumped     (step_taken)
   );

   ecc_trigger_match #(
      .W             (CNT_W),
      .ZERO_DISABLES (ZERO_DISABLES)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (sw_wr_trigger),
      .load_val   (sw_wdata),
      .bumped     (step_taken),
      .bumped_val (step_val),
      .trigger    (trigger_out),
      .hit        (trig_hit)
   );

   assign flag_set[F_SBE] = trig_hit;
   assign flag_set[F_MBE] = multi_evt;
   assign flag_clr[F_SBE] = clr_sbe;
   assign flag_clr[F_MBE] = clr_mbe;

   generate
      for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
         ecc_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[i]),
            .clr   (flag_clr[i]),
            .q     (flag_q[i])
         );
      end
   endgenerate

   assign sbe_flag = flag_q[F_SBE];
   assign mbe_flag = flag_q[F_MBE];

endmodule

// File: rtl/ecc_err_tally_chk.sv
module ecc_err_tally_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ecc_on,
   input logic             rd_valid,
   input logic [1:0]       rd_class,
   input logic             sw_wr_count,
   input logic             sw_wr_trigger,
   input logic [CNT_W-1:0] sw_wdata,
   input logic             clr_sbe,
   input logic             clr_mbe,
   input logic [CNT_W-1:0] count_out,
   input logic [CNT_W-1:0] trigger_out,
   input logic             sbe_flag,
   input logic             mbe_flag
);

   localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

   logic single_rd;
   logic multi_rd;
   assign single_rd = ecc_on && rd_valid && (rd_class == 2'b01);
   assign multi_rd  = ecc_on && rd_valid && rd_class[1];

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (single_rd && !sw_wr_count && count_out != TOPV)
      |=> (count_out - $past(count_out)) == CNT_W'(1));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_rd && !sw_wr_count) |=> $stable(count_out));

   assert_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ecc_on && !sw_wr_count && !clr_mbe) |=> ($stable(count_out) && (mbe_flag || !$rose(mbe_flag))));

   assert_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count_out == TOPV && !sw_wr_count) |=> count_out == TOPV);

   assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sbe_flag) |-> (count_out == $past(trigger_out) && count_out != '0));

   assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trigger_out == '0 && !sbe_flag) |=> !sbe_flag);

   assert_mbe_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      multi_rd |=> mbe_flag);

   assert_mbe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mbe_flag) |-> $past(multi_rd));

   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_count |=> count_out == $past(sw_wdata));

   assert_trig_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_trigger |=> trigger_out == $past(sw_wdata));

endmodule

bind ecc_err_tally ecc_err_tally_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ecc_on        (ecc_on),
   .rd_valid      (rd_valid),
   .rd_class      (rd_class),
   .sw_wr_count   (sw_wr_count),
   .sw_wr_trigger (sw_wr_trigger),
   .sw_wdata      (sw_wdata),
   .clr_sbe       (clr_sbe),
   .clr_mbe       (clr_mbe),
   .count_out     (count_out),
   .trigger_out   (trigger_out),
   .sbe_flag      (sbe_flag),
   .mbe_flag      (mbe_flag)
);

// File: tb/ecc_err_tally_test.sv
module ecc_err_tally_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ecc_on = 1'b0;
   logic       rd_valid = 1'b0;
   logic [1:0] rd_class = 2'b00;
   logic       sw_wr_count = 1'b0;
   logic       sw_wr_trigger = 1'b0;
   logic [7:0] sw_wdata = 8'h00;
   logic       clr_sbe = 1'b0;
   logic       clr_mbe = 1'b0;
   logic [7:0] count_out;
   logic [7:0] trigger_out;
   logic       sbe_flag;
   logic       mbe_flag;

   always #10 clk = ~clk;

   ecc_err_tally uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ecc_on        (ecc_on),
      .rd_valid      (rd_valid),
      .rd_class      (rd_class),
      .sw_wr_count   (sw_wr_count),
      .sw_wr_trigger (sw_wr_trigger),
      .sw_wdata      (sw_wdata),
      .clr_sbe       (clr_sbe),
      .clr_mbe       (clr_mbe),
      .count_out     (count_out),
      .trigger_out   (trigger_out),
      .sbe_flag      (sbe_flag),
      .mbe_flag      (mbe_flag)
   );

   typedef struct {
      logic [7:0] cnt;
      logic [7:0] trg;
      logic       sbe;
      logic       mbe;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   logic [7:0] m_cnt = 8'h00;
   logic [7:0] m_trg = 8'h00;
   logic       m_sbe = 1'b0;
   logic       m_mbe = 1'b0;

   task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic on, input logic v, input logic [1:0] cls,
                        input logic wrc, input logic wrt, input logic [7:0] wd,
                        input logic cs, input logic cm, input string req);
      exp_t e;
      logic inc;
      logic set_s;
      logic set_m;
      @(negedge clk);
      ecc_on = on; rd_valid = v; rd_class = cls;
      sw_wr_count = wrc; sw_wr_trigger = wrt; sw_wdata = wd;
      clr_sbe = cs; clr_mbe = cm;
      inc   = on && v && (cls == 2'b01) && !wrc && (m_cnt != 8'hFF);
      set_s = inc && (m_trg != 8'h00) && (m_cnt + 8'd1 == m_trg);
      set_m = on && v && cls[1];
      if (wrc) m_cnt = wd;
      else if (inc) m_cnt = m_cnt + 8'd1;
      if (wrt) m_trg = wd;
      if (set_s) m_sbe = 1'b1; else if (cs) m_sbe = 1'b0;
      if (set_m) m_mbe = 1'b1; else if (cm) m_mbe = 1'b0;
      e.cnt = m_cnt; e.trg = m_trg; e.sbe = m_sbe; e.mbe = m_mbe; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic single_hit(input string req);
      drive(1, 1, 2'b01, 0, 0, 8'h00, 0, 0, req);
   endtask

   task automatic idle(input string req);
      drive(1, 0, 2'b00, 0, 0, 8'h00, 0, 0, req);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check8(e.req, "count", count_out, e.cnt);
            check8(e.req, "trigger", trigger_out, e.trg);
            check8(e.req, "sbe_flag", {7'd0, sbe_flag}, {7'd0, e.sbe});
            check8(e.req, "mbe_flag", {7'd0, mbe_flag}, {7'd0, e.mbe});
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1", "count after reset", count_out, 8'h00);
      check8("R1", "trigger after reset", trigger_out, 8'h00);
      check8("R1", "flags after reset", {6'd0, sbe_flag, mbe_flag}, 8'h00);

      drive(1, 0, 2'b00, 0, 1, 8'd3, 0, 0, "R11");
      single_hit("R2");
      drive(1, 1, 2'b00, 0, 0, 8'h00, 0, 0, "R2 clean read");
      single_hit("R2");
      single_hit("R5");
      single_hit("R7 past trigger");
      drive(1, 0, 2'b00, 0, 0, 8'h00, 1, 0, "R10 clear sbe");
      single_hit("R7");
      drive(0, 1, 2'b01, 0, 0, 8'h00, 0, 0, "R3 single off");
      drive(0, 1, 2'b10, 0, 0, 8'h00, 0, 0, "R3 multi off");
      drive(1, 1, 2'b10, 0, 0, 8'h00, 0, 0, "R8 code 10");
      drive(1, 0, 2'b00, 0, 0, 8'h00, 0, 1, "R10 clear mbe");
      drive(1, 1, 2'b11, 0, 0, 8'h00, 0, 0, "R8 code 11");
      drive(1, 1, 2'b11, 0, 0, 8'h00, 0, 1, "R10 set beats clear");
      drive(1, 0, 2'b00, 0, 1, 8'd101, 0, 0, "R11");
      drive(1, 1, 2'b01, 1, 0, 8'd100, 0, 0, "R9 load beats inc");
      idle("R9");
      single_hit("R5 at 101");
      drive(1, 1, 2'b01, 0, 0, 8'h00, 1, 0, "R10 clr vs non-match inc");
      drive(1, 0, 2'b00, 1, 1, 8'd254, 0, 0, "R9");
      drive(1, 0, 2'b00, 0, 1, 8'd255, 0, 0, "R11");
      single_hit("R5 reach max");
      drive(1, 0, 2'b00, 0, 0, 8'h00, 1, 0, "R10");
      single_hit("R4 saturate");
      single_hit("R7 no flag at saturation");
      drive(1, 0, 2'b00, 1, 1, 8'd0, 0, 0, "R6 setup");
      for (int i = 0; i < 300; i++) single_hit("R6 zero trigger");
      drive(1, 0, 2'b00, 1, 0, 8'd2, 0, 0, "R9");
      drive(1, 1, 2'b01, 0, 1, 8'd3, 0, 0, "R5 old trigger used");
      idle("R5");
      idle("R2");
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule